// File: doc/BRIEF.md
# Data Watchpoint Match Unit

This block holds a small bank of data-address watchpoints for a processor's load/store path. Each watchpoint has an address value and a control word, and both are written through a simple register write port. Every access the core presents is compared with all enabled watchpoints. The access is described by its address, its size, its direction and an unprivileged flag. One clock later the unit reports whether any watchpoint fired. When one fires, it also reports the access address and whether the access was a write.

A watchpoint's address window takes one of two forms:
- **Masked region:** an aligned block of 2^m bytes, used when the mask field holds a legal non-zero value.
- **Byte-select range:** a contiguous byte range picked by an 8-bit byte-select field, used when the mask field is zero.

Before an entry may fire, its window must also pass filters on access direction, processor security state and privilege level. An entry can also require an external linked context comparator to agree. Two global inputs gate every hit: a global watchpoint enable and a debug-allowed signal. Raising an exception from a hit is left to the surrounding logic.

Top module: `wp_match_unit`

Control word layout (written with `cfg_ctrl_i`=1):

| Bits | Field | Meaning |
|---|---|---|
| 0 | enable | Entry is active when set |
| 2:1 | privilege select | Bit 1 allows level 1; bit 2 allows level 0 |
| 4:3 | direction | 0 = disabled, 1 = loads, 2 = stores, 3 = both |
| 12:5 | byte select | 8-bit byte-select field |
| 13 | higher mode | Allows levels 2 and 3 |
| 15:14 | security | Security filter |
| 16 | link | Requires the linked context match |
| 21:17 | mask | 5-bit mask field |

## Requirements
- R1: After reset, `hit_o`, `hit_wnr_o` and `hit_addr_o` are zero, and every entry is disabled.
- R2: An entry fires only if enable (bit 0) is set and the direction field [4:3] allows the access. Direction 0 disables the entry, 1 allows loads, 2 allows stores and 3 allows both.
- R3: When the mask field [21:17] holds m >= 3, the window is the 2^m-byte aligned block containing the value address. The value's low m bits are ignored. Mask values 1 and 2 disable the entry.
- R4: With mask 0, the window starts at the value address plus the number of trailing zeros in the byte-select field [12:5]. It is as long as the first run of ones from that point. Set bits after that run are ignored, and a zero select value disables the entry.
- R5: With mask 0 and bit 2 of the value register set, only byte-select bits [3:0] are used.
- R6: When the mask field is non-zero, the byte-select field has no effect.
- R7: A write to the value register (`cfg_ctrl_i`=0) stores data bits [1:0] as zero. The rest of the register takes part in the comparison.
- R8: The security field [15:14] filters on `secure_i`. Value 0 passes any state, 2 passes secure only, and 1 or 3 pass non-secure only.
- R9: The effective level is 0 when `acc_unpriv_i` is set, and `cur_level_i` otherwise. Level 0 requires privilege bit 2, level 1 requires privilege bit 1, and levels 2 and 3 require the higher-mode bit 13.
- R10: When the link bit 16 is set, entry i fires only while `link_match_i[i]` is high.
- R11: When `big_endian_wi_i` is set, a byte access is compared at address XOR 3 and a halfword access at address XOR 2. Wider accesses are compared unchanged.
- R12: An access fires when its byte span [addr, addr + 2^size) overlaps a qualifying window. It also needs `acc_valid_i`, `wp_global_en_i` and `dbg_allow_i` all high. `hit_o` rises in the following cycle, together with the presented address on `hit_addr_o` and the write flag on `hit_wnr_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_ctrl_i | input | 1 | 1 selects the control word, 0 selects the value register |
| cfg_idx_i | input | IW | Entry index for the write |
| cfg_data_i | input | AW | Write data; control uses bits [21:0] |
| acc_valid_i | input | 1 | Access present this cycle |
| acc_addr_i | input | AW | Access byte address |
| acc_size_i | input | 2 | Access size as log2 of the byte count |
| acc_write_i | input | 1 | 1 for a store, 0 for a load |
| acc_unpriv_i | input | 1 | Unprivileged load/store |
| cur_level_i | input | 2 | Current privilege level |
| secure_i | input | 1 | Processor security state |
| wp_global_en_i | input | 1 | Global watchpoint enable |
| dbg_allow_i | input | 1 | Debug exceptions currently permitted |
| big_endian_wi_i | input | 1 | Word-invariant big-endian mode |
| link_match_i | input | NUM_WP | Linked context comparator result per entry |
| hit_o | output | 1 | Watchpoint hit, registered |
| hit_wnr_o | output | 1 | The hit access was a write |
| hit_addr_o | output | AW | Address of the hit access |

## Verification
The assertions assume that any registered hit traces back to the access presented one cycle earlier. They also assume that the access was valid and gated on, and that configuration writes never arrive in the same cycle as the access they would change. The bench keeps to these assumptions by driving each access alone, one cycle after any register write, with the global gates held steady until the result is sampled. The overlap checks assume that no window wraps past the top of the address space, so every programmed window and access sits well inside the low address range.

// File: rtl/wp_match_unit.sv
module wp_match_unit #(
  parameter int NUM_WP = 4,
  parameter int AW     = 32,
  parameter int IW     = (NUM_WP > 1) ? $clog2(NUM_WP) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic              cfg_ctrl_i,
  input  logic [IW-1:0]     cfg_idx_i,
  input  logic [AW-1:0]     cfg_data_i,
  input  logic              acc_valid_i,
  input  logic [AW-1:0]     acc_addr_i,
  input  logic [1:0]        acc_size_i,
  input  logic              acc_write_i,
  input  logic              acc_unpriv_i,
  input  logic [1:0]        cur_level_i,
  input  logic              secure_i,
  input  logic              wp_global_en_i,
  input  logic              dbg_allow_i,
  input  logic              big_endian_wi_i,
  input  logic [NUM_WP-1:0] link_match_i,
  output logic              hit_o,
  output logic              hit_wnr_o,
  output logic [AW-1:0]     hit_addr_o
);
  localparam int CW = 22;
  localparam int XW = AW + 1;

  function automatic logic [3:0] first_one(input logic [7:0] b);
    logic [3:0] r;
    r = 4'd8;
    for (int k = 7; k >= 0; k--) if (b[k]) r = 4'(k);
    return r;
  endfunction

  function automatic logic [3:0] run_len(input logic [7:0] b, input logic [3:0] s);
    logic [3:0] n;
    logic       stop;
    n = '0;
    stop = 1'b0;
    for (int k = 0; k < 8; k++) begin
      if (k >= int'(s) && !stop) begin
        if (b[k]) n = n + 4'd1;
        else      stop = 1'b1;
      end
    end
    return n;
  endfunction

  logic [AW-1:0] addr_eff;
  logic [XW-1:0] a_lo, a_hi;
  logic [1:0]    lvl_eff;
  logic [NUM_WP-1:0] ent_hit, ent_live;
  logic          fire;

  always_comb begin
    addr_eff = acc_addr_i;
    if (big_endian_wi_i) begin
      if (acc_size_i == 2'd0)      addr_eff = acc_addr_i ^ AW'(3);
      else if (acc_size_i == 2'd1) addr_eff = acc_addr_i ^ AW'(2);
    end
  end

  assign a_lo    = {1'b0, addr_eff};
  assign a_hi    = a_lo + (XW'(1) << acc_size_i);
  assign lvl_eff = acc_unpriv_i ? 2'd0 : cur_level_i;

  for (genvar i = 0; i < NUM_WP; i++) begin : g_ent
    logic [AW-1:0] val_q;
    logic [CW-1:0] ctl_q;
    logic [1:0]    priv, lsc, ssc;
    logic [7:0]    bsel, bs;
    logic [4:0]    msk;
    logic          hmc, lnk, win_ok, lvl_ok, sec_ok, dir_ok;
    logic [3:0]    tz, rl;
    logic [XW-1:0] w_lo, w_hi, span;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        val_q <= '0;
        ctl_q <= '0;
      end else if (cfg_we_i && cfg_idx_i == IW'(i)) begin
        if (cfg_ctrl_i) ctl_q <= cfg_data_i[CW-1:0];
        else            val_q <= {cfg_data_i[AW-1:2], 2'b00};
      end
    end

    assign priv = ctl_q[2:1];
    assign lsc  = ctl_q[4:3];
    assign bsel = ctl_q[12:5];
    assign hmc  = ctl_q[13];
    assign ssc  = ctl_q[15:14];
    assign lnk  = ctl_q[16];
    assign msk  = ctl_q[21:17];

    assign bs = val_q[2] ? {4'b0, bsel[3:0]} : bsel;
    assign tz = first_one(bs);
    assign rl = run_len(bs, tz);

    always_comb begin
      span = XW'(1) << msk;
      if (msk != 5'd0) begin
        win_ok = (msk >= 5'd3);
        w_lo   = {1'b0, val_q} & ~(span - XW'(1));
        w_hi   = w_lo + span;
      end else begin
        win_ok = (bs != 8'd0);
        w_lo   = {1'b0, val_q} + XW'(tz);
        w_hi   = w_lo + XW'(rl);
      end
    end

    always_comb begin
      case (lvl_eff)
        2'd0:    lvl_ok = priv[1];
        2'd1:    lvl_ok = priv[0];
        default: lvl_ok = hmc;
      endcase
    end

    assign sec_ok = (ssc == 2'd0) || ((ssc == 2'd2) ? secure_i : !secure_i);
    assign dir_ok = acc_write_i ? lsc[1] : lsc[0];
    assign ent_live[i] = ctl_q[0] && (lsc != 2'd0);
    assign ent_hit[i]  = ctl_q[0] && win_ok && dir_ok && lvl_ok && sec_ok &&
                         (!lnk || link_match_i[i]) &&
                         (a_lo < w_hi) && (w_lo < a_hi);
  end

  assign fire = acc_valid_i && wp_global_en_i && dbg_allow_i && (|ent_hit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hit_o      <= 1'b0;
      hit_wnr_o  <= 1'b0;
      hit_addr_o <= '0;
    end else begin
      hit_o <= fire;
      if (fire) begin
        hit_wnr_o  <= acc_write_i;
        hit_addr_o <= acc_addr_i;
      end
    end
  end

  assert_idle_no_hit_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc_valid_i |=> !hit_o);
  assert_gate_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wp_global_en_i && dbg_allow_i) |=> !hit_o);
  assert_wnr_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_valid_i ##1 hit_o |-> hit_wnr_o == $past(acc_write_i));
  assert_addr_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_valid_i ##1 hit_o |-> hit_addr_o == $past(acc_addr_i));
  assert_no_entry_no_hit_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|ent_live) |=> !hit_o);
endmodule

// File: tb/sim_wp_match_unit.sv
module sim_wp_match_unit;
  localparam int NW = 4;
  localparam int AW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0, cfg_ctrl = 1'b0;
  logic [1:0] cfg_idx = '0;
  logic [AW-1:0] cfg_data = '0;
  logic acc_valid = 1'b0, acc_write = 1'b0, acc_unpriv = 1'b0;
  logic [AW-1:0] acc_addr = '0;
  logic [1:0] acc_size = '0, cur_level = 2'd1;
  logic secure = 1'b0, gen = 1'b1, dbg = 1'b1, bewi = 1'b0;
  logic [NW-1:0] link = '0;
  logic hit, wnr;
  logic [AW-1:0] haddr;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  wp_match_unit #(.NUM_WP(NW), .AW(AW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_ctrl_i(cfg_ctrl),
    .cfg_idx_i(cfg_idx), .cfg_data_i(cfg_data), .acc_valid_i(acc_valid),
    .acc_addr_i(acc_addr), .acc_size_i(acc_size), .acc_write_i(acc_write),
    .acc_unpriv_i(acc_unpriv), .cur_level_i(cur_level), .secure_i(secure),
    .wp_global_en_i(gen), .dbg_allow_i(dbg), .big_endian_wi_i(bewi),
    .link_match_i(link), .hit_o(hit), .hit_wnr_o(wnr), .hit_addr_o(haddr));

  typedef struct packed {
    logic [31:0] a; logic [1:0] sz; logic wr; logic up;
    logic [1:0] lv; logic sc; logic lk; logic ex; logic [3:0] rq;
  } vec_t;

  localparam int NV = 29;
  localparam vec_t VEC [NV] = '{
    '{32'h1002, 2'd0, 1'b0, 1'b0, 2'd1, 1'b0, 1'b0, 1'b1, 4'd4}, // R4 first byte
    '{32'h1001, 2'd0, 1'b0, 1'b0, 2'd1, 1'b0, 1'b0, 1'b0, 4'd4}, // R4 below
    '{32'h1000, 2'd2, 1'b0, 1'b0, 2'd1, 1'b0, 1'b0, 1'b1, 4'd4}, // R4 overlap
    '{32'h1006, 2'd0, 1'b0, 1'b0, 2'd1, 1'b0, 1'b0, 1'b0, 4'd4}, // R4 past run
    '{32'h1007, 2'd0, 1'b0, 1'b0, 2'd1, 1'b0, 1'b0, 1'b0, 4'd4}, // R4 stray bit
    '{32'h1005, 2'd0, 1'b1, 1'b0, 2'd1, 1'b0, 1'b0, 1'b1, 4'd2}, // R2 both dirs
    '{32'h1002, 2'd0, 1'b0, 1'b0, 2'd2, 1'b0, 1'b0, 1'b1, 4'd9}, // R9 higher mode
    '{32'h1002, 2'd0, 1'b0, 1'b0, 2'd1, 1'b1, 1'b0, 1'b0, 4'd8}, // R8 ns only
    '{32'h2080, 2'd0, 1'b1, 1'b0, 2'd1, 1'b0, 1'b0, 1'b1, 4'd6}, // R6 R3 region
    '{32'h2080, 2'd0, 1'b0, 1'b0, 2'd1, 1'b0, 1'b0, 1'b0, 4'd2}, // R2 stores only
    '{32'h2000, 2'd0, 1'b1, 1'b0, 2'd1, 1'b0, 1'b0, 1'b1, 4'd3}, // R3 low bits ignored
    '{32'h20FF, 2'd0, 1'b1, 1'b0, 2'd1, 1'b0, 1'b0, 1'b1, 4'd3}, // R3 top
    '{32'h2100, 2'd0, 1'b1, 1'b0, 2'd1, 1'b0, 1'b0, 1'b0, 4'd3}, // R3 past
    '{32'h1FF8, 2'd3, 1'b1, 1'b0, 2'd1, 1'b0, 1'b0, 1'b0, 4'd12}, // R12 abut
    '{32'h1FFC, 2'd3, 1'b1, 1'b0, 2'd1, 1'b0, 1'b0, 1'b1, 4'd12}, // R12 straddle
    '{32'h3005, 2'd0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b1, 4'd5}, // R5
    '{32'h3004, 2'd0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 4'd5}, // R5
    '{32'h3007, 2'd0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b1, 4'd5}, // R5
    '{32'h3008, 2'd0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 4'd5}, // R5 high nibble dropped
    '{32'h3005, 2'd0, 1'b0, 1'b1, 2'd1, 1'b0, 1'b0, 1'b1, 4'd9}, // R9 unpriv as level 0
    '{32'h3005, 2'd0, 1'b0, 1'b0, 2'd1, 1'b0, 1'b0, 1'b0, 4'd9}, // R9
    '{32'h4000, 2'd0, 1'b0, 1'b0, 2'd1, 1'b1, 1'b1, 1'b1, 4'd10}, // R10
    '{32'h4000, 2'd0, 1'b0, 1'b0, 2'd1, 1'b0, 1'b1, 1'b0, 4'd8}, // R8 secure only
    '{32'h4000, 2'd0, 1'b0, 1'b0, 2'd1, 1'b1, 1'b0, 1'b0, 4'd10}, // R10 no link
    '{32'h4000, 2'd0, 1'b0, 1'b0, 2'd0, 1'b1, 1'b1, 1'b0, 4'd9}, // R9 level 0
    '{32'h4000, 2'd0, 1'b0, 1'b1, 2'd1, 1'b1, 1'b1, 1'b0, 4'd9}, // R9 unpriv
    '{32'h4000, 2'd0, 1'b0, 1'b0, 2'd2, 1'b1, 1'b1, 1'b0, 4'd9}, // R9 no hmc
    '{32'h4000, 2'd0, 1'b1, 1'b0, 2'd1, 1'b1, 1'b1, 1'b0, 4'd2}, // R2 loads only
    '{32'h4003, 2'd0, 1'b0, 1'b0, 2'd1, 1'b1, 1'b1, 1'b0, 4'd7}  // R7 low bits cleared
  };

  function automatic logic [31:0] mkctl(input logic en, input logic [1:0] pv,
      input logic [1:0] ls, input logic [7:0] bsl, input logic hm,
      input logic [1:0] sc, input logic ln, input logic [4:0] mk);
    return {10'b0, mk, ln, sc, hm, bsl, ls, pv, en};
  endfunction

  task automatic chk(input logic [AW-1:0] act, input logic [AW-1:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input int idx, input logic ctl, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 2'(idx); cfg_ctrl = ctl; cfg_data = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic access(input logic [31:0] a, input logic [1:0] sz, input logic w,
      input logic up, input logic [1:0] lv, input logic sc, input logic lk);
    @(negedge clk);
    acc_valid = 1'b1; acc_addr = a; acc_size = sz; acc_write = w;
    acc_unpriv = up; cur_level = lv; secure = sc; link = {NW{lk}};
    @(negedge clk);
    acc_valid = 1'b0;
  endtask

  task automatic finish_sim();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_sim();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(AW'(hit), 0, "R1 hit after reset");
    chk(haddr, 0, "R1 address after reset");
    rst_n = 1'b1;
    access(32'h1002, 2'd0, 1'b0, 1'b0, 2'd1, 1'b0, 1'b0);
    chk(AW'(hit), 0, "R1 entries disabled after reset");

    wr_reg(0, 1'b0, 32'h1000);
    wr_reg(0, 1'b1, mkctl(1'b1, 2'b11, 2'd3, 8'hBC, 1'b1, 2'd1, 1'b0, 5'd0));
    wr_reg(1, 1'b0, 32'h2044);
    wr_reg(1, 1'b1, mkctl(1'b1, 2'b11, 2'd2, 8'h01, 1'b0, 2'd0, 1'b0, 5'd8));
    wr_reg(2, 1'b0, 32'h3004);
    wr_reg(2, 1'b1, mkctl(1'b1, 2'b10, 2'd3, 8'h3E, 1'b0, 2'd0, 1'b0, 5'd0));
    wr_reg(3, 1'b0, 32'h4003);
    wr_reg(3, 1'b1, mkctl(1'b1, 2'b01, 2'd1, 8'h01, 1'b0, 2'd2, 1'b1, 5'd0));

    for (int v = 0; v < NV; v++) begin
      access(VEC[v].a, VEC[v].sz, VEC[v].wr, VEC[v].up, VEC[v].lv, VEC[v].sc, VEC[v].lk);
      chk(AW'(hit), AW'(VEC[v].ex), $sformatf("R%0d vector %0d", VEC[v].rq, v));
    end

    access(32'h1005, 2'd0, 1'b1, 1'b0, 2'd1, 1'b0, 1'b0);
    chk(AW'(hit), 1, "R12 store hit");
    chk(AW'(wnr), 1, "R12 write flag");
    chk(haddr, 32'h1005, "R12 store address");
    access(32'h1003, 2'd0, 1'b0, 1'b0, 2'd1, 1'b0, 1'b0);
    chk(AW'(wnr), 0, "R12 read flag");
    chk(haddr, 32'h1003, "R12 read address");

    gen = 1'b0;
    access(32'h1002, 2'd0, 1'b0, 1'b0, 2'd1, 1'b0, 1'b0);
    chk(AW'(hit), 0, "R12 global enable off");
    gen = 1'b1; dbg = 1'b0;
    access(32'h1002, 2'd0, 1'b0, 1'b0, 2'd1, 1'b0, 1'b0);
    chk(AW'(hit), 0, "R12 debug disallowed");
    dbg = 1'b1;

    bewi = 1'b1;
    access(32'h1005, 2'd0, 1'b0, 1'b0, 2'd1, 1'b0, 1'b0);
    chk(AW'(hit), 0, "R11 byte swizzled away");
    access(32'h1006, 2'd0, 1'b0, 1'b0, 2'd1, 1'b0, 1'b0);
    chk(AW'(hit), 1, "R11 byte swizzled in");
    chk(haddr, 32'h1006, "R11 reported address unswizzled");
    access(32'h1004, 2'd1, 1'b0, 1'b0, 2'd1, 1'b0, 1'b0);
    chk(AW'(hit), 0, "R11 halfword swizzled away");
    access(32'h1006, 2'd1, 1'b0, 1'b0, 2'd1, 1'b0, 1'b0);
    chk(AW'(hit), 1, "R11 halfword swizzled in");
    access(32'h1004, 2'd2, 1'b0, 1'b0, 2'd1, 1'b0, 1'b0);
    chk(AW'(hit), 1, "R11 word unchanged");
    bewi = 1'b0;

    wr_reg(1, 1'b1, mkctl(1'b1, 2'b11, 2'd2, 8'h01, 1'b0, 2'd0, 1'b0, 5'd1));
    access(32'h2044, 2'd0, 1'b1, 1'b0, 2'd1, 1'b0, 1'b0);
    chk(AW'(hit), 0, "R3 mask 1 reserved");
    wr_reg(1, 1'b1, mkctl(1'b1, 2'b11, 2'd2, 8'h01, 1'b0, 2'd0, 1'b0, 5'd2));
    access(32'h2044, 2'd0, 1'b1, 1'b0, 2'd1, 1'b0, 1'b0);
    chk(AW'(hit), 0, "R3 mask 2 reserved");

    wr_reg(3, 1'b1, mkctl(1'b1, 2'b01, 2'd1, 8'h00, 1'b0, 2'd2, 1'b1, 5'd0));
    access(32'h4000, 2'd0, 1'b0, 1'b0, 2'd1, 1'b1, 1'b1);
    chk(AW'(hit), 0, "R4 zero select disables");

    wr_reg(2, 1'b1, mkctl(1'b1, 2'b10, 2'd0, 8'h3E, 1'b0, 2'd0, 1'b0, 5'd0));
    access(32'h3005, 2'd0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0);
    chk(AW'(hit), 0, "R2 direction 0 disables");
    wr_reg(0, 1'b1, mkctl(1'b0, 2'b11, 2'd3, 8'hBC, 1'b1, 2'd1, 1'b0, 5'd0));
    access(32'h1002, 2'd0, 1'b0, 1'b0, 2'd1, 1'b0, 1'b0);
    chk(AW'(hit), 0, "R2 enable clear");

    done = 1'b1;
    finish_sim();
  end
endmodule